// File: doc/BRIEF.md
# Pipelined AES-128 Block Encryptor

This block encrypts 128-bit blocks with AES-128. The ten cipher rounds are unrolled, and a register closes each round. A further register at the entry holds the whitened input. The block can accept a new plaintext and a new cipher key on every clock. Once the pipe has filled, one ciphertext leaves on every clock. A valid flag travels beside each block, so the output side sees exactly the sequence of accepted inputs, in order, with the same gaps.

The key moves down the pipe with its block. Each stage derives its own round key from the round key registered in the stage before it. As a result, consecutive blocks may use unrelated keys. Every byte substitution uses a composite-field S-box, both in the state path and in the key schedule. The S-box inverts in GF((2^4)^2), and the change of basis in and out of that field is computed when the design is elaborated. The MixColumns step uses only XOR and the one-bit shift-and-reduce multiply.

There is no stall: a block that enters is always delivered, unless a synchronous reset arrives first. That reset drops every block in flight.

Top module: `aes128_pipe_enc`

## Requirements
- R1: Blocks are big-endian: bits 127:120 carry byte 0 of the plaintext, key and ciphertext. Key 000102030405060708090A0B0C0D0E0F with plaintext 00112233445566778899AABBCCDDEEFF yields ciphertext 69C4E0D86A7B0430D8CDB78070B4C55A.
- R2: A block sampled on a rising edge with in_valid high appears on ciphertext with out_valid high exactly 11 rising edges later. After reset, out_valid never rises earlier than that.
- R3: A block is accepted on every clock that has in_valid high. Back-to-back inputs give out_valid on consecutive clocks, with exactly one output per input, in input order.
- R4: The key is sampled together with each block, so a different key on every consecutive clock encrypts each block under its own key.
- R5: out_valid is in_valid delayed by the pipe. A clock with in_valid low produces no output, whatever values plaintext and key carry.
- R6: A synchronous reset (rst high at a rising edge) clears every valid flag. After that edge, out_valid is low, and no block that was in flight or presented on the reset edge ever emerges.
- R7: The tenth round leaves out MixColumns. Key 2B7E151628AED2A6ABF7158809CF4F3C with plaintext 3243F6A8885A308D313198A2E0370734 yields 3925841D02DC09FBDC118597196A0B32.
- R8: Substitution is the standard AES S-box (00 maps to 63, 53 maps to ED, and no non-zero byte maps to 63). An all-zero key with an all-zero plaintext yields 66E94BD4EF8A2C3B884CFA59CA342B2E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers capture on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the valid flags |
| in_valid | input | 1 | Marks plaintext and key as a block to encrypt on this edge |
| plaintext | input | 128 | Input block, byte 0 in bits 127:120 |
| key | input | 128 | Cipher key for this block, byte 0 in bits 127:120 |
| out_valid | output | 1 | Marks ciphertext as a finished block |
| ciphertext | output | 128 | Encrypted block, byte 0 in bits 127:120 |

## Verification
The assertions check on every clock the behaviour of the flags and the S-box:
- each stage's valid flag follows the one before it, whether high or low;
- reset empties every stage;
- out_valid never appears before the pipe could have filled after reset;
- a composite-field S-box never maps a non-zero byte to 63.

The ciphertext values themselves are shown only by the bench's scenarios, where a behavioural cipher model predicts each block and its arrival clock:
- the three known-answer blocks;
- back-to-back streams with a fixed key and with a new key on every clock;
- a stream with gaps and noise on the idle inputs;
- a reset that lands while blocks are in flight.

// File: rtl/aes_pipe_pkg.sv
`timescale 1ns/1ps
package aes_pipe_pkg;

   localparam int BLK_W    = 128;
   localparam int WORD_W   = 32;
   localparam int BYTE_W   = 8;
   localparam int NIB_W    = 4;
   localparam int N_BYTES  = BLK_W / BYTE_W;
   localparam int N_WORDS  = BLK_W / WORD_W;
   localparam int MAX_RND  = 10;
   localparam logic [BYTE_W-1:0] AFF_CONST = 8'h63;
   localparam logic [BYTE_W-1:0] RED_POLY  = 8'h1b;

   typedef logic [NIB_W-1:0]  nib_t;
   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [WORD_W-1:0] word_t;
   typedef logic [BLK_W-1:0]  blk_t;

   // GF(2^4) with reduction x^4 + x + 1
   function automatic nib_t gf16_mul(input nib_t a, input nib_t b);
      nib_t acc;
      nib_t t;
      acc = '0;
      t   = a;
      for (int i = 0; i < NIB_W; i++) begin
         if (b[i]) acc = acc ^ t;
         t = t[3] ? ((t << 1) ^ 4'h3) : (t << 1);
      end
      return acc;
   endfunction

   function automatic nib_t gf16_sq(input nib_t a);
      return gf16_mul(a, a);
   endfunction

   // a^14 = a^-1 for non-zero a, 0 for 0
   function automatic nib_t gf16_inv(input nib_t a);
      nib_t a2;
      nib_t a4;
      nib_t a8;
      a2 = gf16_sq(a);
      a4 = gf16_sq(a2);
      a8 = gf16_sq(a4);
      return gf16_mul(gf16_mul(a8, a4), a2);
   endfunction

   // smallest lambda making y^2 + y + lambda irreducible over GF(2^4)
   function automatic nib_t pick_lambda();
      nib_t res;
      bit   found;
      res   = '0;
      found = 1'b0;
      for (int l = 1; l < 16; l++) begin
         bit has_root;
         has_root = 1'b0;
         for (int t = 0; t < 16; t++)
            if ((gf16_sq(nib_t'(t)) ^ nib_t'(t)) == nib_t'(l)) has_root = 1'b1;
         if (!has_root && !found) begin
            res   = nib_t'(l);
            found = 1'b1;
         end
      end
      return res;
   endfunction

   localparam nib_t CF_LAMBDA = pick_lambda();

   // multiply in GF((2^4)^2): element = hi*y + lo, y^2 = y + lambda
   function automatic byte_t cf_mul(input byte_t a, input byte_t b);
      nib_t hh;
      hh = gf16_mul(a[7:4], b[7:4]);
      return {hh ^ gf16_mul(a[7:4], b[3:0]) ^ gf16_mul(a[3:0], b[7:4]),
              gf16_mul(hh, CF_LAMBDA) ^ gf16_mul(a[3:0], b[3:0])};
   endfunction

   function automatic byte_t cf_inv(input byte_t a);
      nib_t d;
      nib_t di;
      d  = gf16_mul(gf16_sq(a[7:4]), CF_LAMBDA) ^ gf16_mul(a[7:4], a[3:0]) ^ gf16_sq(a[3:0]);
      di = gf16_inv(d);
      return {gf16_mul(a[7:4], di), gf16_mul(a[7:4] ^ a[3:0], di)};
   endfunction

   // linear map given as eight column bytes, column i at bits 8i+7:8i
   function automatic byte_t apply_map(input logic [63:0] m, input byte_t x);
      byte_t r;
      r = '0;
      for (int i = 0; i < BYTE_W; i++)
         if (x[i]) r = r ^ m[i*BYTE_W +: BYTE_W];
      return r;
   endfunction

   // forward basis change: powers of a composite-field root of the AES polynomial
   function automatic logic [63:0] build_fwd_map();
      logic [63:0] res;
      bit          found;
      res   = '0;
      found = 1'b0;
      for (int b = 2; b < 256; b++) begin
         byte_t       pw;
         byte_t       p;
         logic [63:0] cols;
         pw   = 8'h01;
         p    = '0;
         cols = '0;
         for (int k = 0; k <= BYTE_W; k++) begin
            if (k == 0 || k == 1 || k == 3 || k == 4 || k == 8) p = p ^ pw;
            if (k < BYTE_W) cols[k*BYTE_W +: BYTE_W] = pw;
            pw = cf_mul(pw, byte_t'(b));
         end
         if (p == 8'h00 && !found) begin
            res   = cols;
            found = 1'b1;
         end
      end
      return res;
   endfunction

   localparam logic [63:0] MAP_FWD = build_fwd_map();

   function automatic logic [63:0] build_inv_map();
      logic [63:0] res;
      res = '0;
      for (int j = 0; j < BYTE_W; j++)
         for (int a = 0; a < 256; a++)
            if (apply_map(MAP_FWD, byte_t'(a)) == (byte_t'(1) << j))
               res[j*BYTE_W +: BYTE_W] = byte_t'(a);
      return res;
   endfunction

   localparam logic [63:0] MAP_INV = build_inv_map();

   function automatic byte_t affine_out(input byte_t a);
      return a ^ {a[6:0], a[7]} ^ {a[5:0], a[7:6]} ^ {a[4:0], a[7:5]} ^ {a[3:0], a[7:4]}
             ^ AFF_CONST;
   endfunction

   function automatic byte_t xtime(input byte_t b);
      return {b[6:0], 1'b0} ^ (b[7] ? RED_POLY : 8'h00);
   endfunction

   function automatic byte_t rcon_at(input int idx);
      byte_t r;
      r = 8'h01;
      for (int i = 1; i < idx; i++) r = xtime(r);
      return r;
   endfunction

   // byte k of the state sits at bits 127-8k : 120-8k; byte (row r, column c) is k = 4c + r
   function automatic blk_t shift_rows(input blk_t s);
      blk_t o;
      o = '0;
      for (int c = 0; c < N_WORDS; c++)
         for (int r = 0; r < 4; r++)
            o[BLK_W-1-BYTE_W*(4*c+r) -: BYTE_W] =
               s[BLK_W-1-BYTE_W*(4*((c+r)%4)+r) -: BYTE_W];
      return o;
   endfunction

   function automatic word_t mix_column(input word_t col);
      byte_t a0, a1, a2, a3;
      a0 = col[31:24];
      a1 = col[23:16];
      a2 = col[15:8];
      a3 = col[7:0];
      return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
              a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
              a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
              xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
   endfunction

endpackage

// File: rtl/aes_cf_sbox.sv
`timescale 1ns/1ps
module aes_cf_sbox
   import aes_pipe_pkg::*;
(
   input  logic [BYTE_W-1:0] din,
   output logic [BYTE_W-1:0] dout
);

   byte_t in_cf;
   byte_t inv_cf;
   byte_t inv_std;

   always_comb begin
      in_cf   = apply_map(MAP_FWD, din);
      inv_cf  = cf_inv(in_cf);
      inv_std = apply_map(MAP_INV, inv_cf);
      dout    = affine_out(inv_std);
   end

   always_comb begin
      AST_SBOX_ZERO_ONLY: assert (din == 8'h00 || dout != AFF_CONST); // R8
   end

endmodule

// File: rtl/aes_key_step.sv
`timescale 1ns/1ps
module aes_key_step
   import aes_pipe_pkg::*;
#(
   parameter logic [7:0] RCON = 8'h01
)(
   input  logic [BLK_W-1:0] key_in,
   output logic [BLK_W-1:0] key_out
);

   localparam int SUB_BYTES = WORD_W / BYTE_W;

   word_t w0, w1, w2, w3;
   word_t rot;
   word_t sub;
   word_t mixw;
   word_t n0, n1, n2, n3;

   assign w0  = key_in[127:96];
   assign w1  = key_in[95:64];
   assign w2  = key_in[63:32];
   assign w3  = key_in[31:0];
   assign rot = {w3[23:0], w3[31:24]};

   for (genvar i = 0; i < SUB_BYTES; i++) begin : g_sub
      aes_cf_sbox u_sb (
         .din  (rot[WORD_W-1-BYTE_W*i -: BYTE_W]),
         .dout (sub[WORD_W-1-BYTE_W*i -: BYTE_W])
      );
   end

   assign mixw = sub ^ {RCON, 24'h000000};
   assign n0   = w0 ^ mixw;
   assign n1   = w1 ^ n0;
   assign n2   = w2 ^ n1;
   assign n3   = w3 ^ n2;

   assign key_out = {n0, n1, n2, n3};

endmodule

// File: rtl/aes_round_stage.sv
`timescale 1ns/1ps
module aes_round_stage
   import aes_pipe_pkg::*;
#(
   parameter bit FINAL      = 1'b0,
   parameter bit CLEAR_DATA = 1'b0
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             v_in,
   input  logic [BLK_W-1:0] st_in,
   input  logic [BLK_W-1:0] rk,
   output logic             v_out,
   output logic [BLK_W-1:0] st_out
);

   blk_t subbed;
   blk_t shifted;
   blk_t mixed;
   blk_t nxt;

   for (genvar b = 0; b < N_BYTES; b++) begin : g_sb
      aes_cf_sbox u_sb (
         .din  (st_in [BLK_W-1-BYTE_W*b -: BYTE_W]),
         .dout (subbed[BLK_W-1-BYTE_W*b -: BYTE_W])
      );
   end

   assign shifted = shift_rows(subbed);

   if (FINAL) begin : g_nomix
      assign mixed = shifted;
   end else begin : g_mix
      for (genvar c = 0; c < N_WORDS; c++) begin : g_col
         assign mixed[BLK_W-1-WORD_W*c -: WORD_W] =
            mix_column(shifted[BLK_W-1-WORD_W*c -: WORD_W]);
      end
   end

   assign nxt = mixed ^ rk;

   always_ff @(posedge clk) begin
      if (rst) v_out <= 1'b0;
      else     v_out <= v_in;
   end

   if (CLEAR_DATA) begin : g_data_rst
      always_ff @(posedge clk) begin
         if (rst)       st_out <= '0;
         else if (v_in) st_out <= nxt;
      end
   end else begin : g_data_free
      always_ff @(posedge clk) begin
         if (v_in) st_out <= nxt;
      end
   end

   AST_VALID_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      v_in |=> v_out); // R5
   AST_IDLE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      !v_in |=> !v_out); // R5
   AST_RST_FLUSH: assert property (@(posedge clk)
      rst |=> !v_out); // R6

endmodule

// File: rtl/aes128_pipe_enc.sv
`timescale 1ns/1ps
module aes128_pipe_enc
   import aes_pipe_pkg::*;
#(
   parameter int NR         = 10,
   parameter bit CLEAR_DATA = 1'b0
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [BLK_W-1:0] plaintext,
   input  logic [BLK_W-1:0] key,
   output logic             out_valid,
   output logic [BLK_W-1:0] ciphertext
);

   localparam int LAT   = NR + 1;
   localparam int CNT_W = $clog2(LAT + 1);

   if (NR < 1 || NR > MAX_RND) begin : g_bad_rounds
      $error("aes128_pipe_enc: NR must lie in 1..10");
   end

   logic             v_chain  [0:NR];
   logic [BLK_W-1:0] st_chain [0:NR];
   logic [BLK_W-1:0] rk_q     [0:NR-1];
   logic [BLK_W-1:0] rk_nxt   [1:NR];

   logic             v0_q;
   logic [BLK_W-1:0] st0_q;

   // entry stage: initial whitening with the cipher key
   always_ff @(posedge clk) begin
      if (rst) v0_q <= 1'b0;
      else     v0_q <= in_valid;
   end

   if (CLEAR_DATA) begin : g_entry_rst
      always_ff @(posedge clk) begin
         if (rst) begin
            st0_q   <= '0;
            rk_q[0] <= '0;
         end else if (in_valid) begin
            st0_q   <= plaintext ^ key;
            rk_q[0] <= key;
         end
      end
   end else begin : g_entry_free
      always_ff @(posedge clk) begin
         if (in_valid) begin
            st0_q   <= plaintext ^ key;
            rk_q[0] <= key;
         end
      end
   end

   assign v_chain[0]  = v0_q;
   assign st_chain[0] = st0_q;

   for (genvar r = 1; r <= NR; r++) begin : g_rnd
      localparam logic [7:0] RC = rcon_at(r);

      aes_key_step #(.RCON(RC)) u_ks (
         .key_in  (rk_q[r-1]),
         .key_out (rk_nxt[r])
      );

      aes_round_stage #(
         .FINAL      (r == NR),
         .CLEAR_DATA (CLEAR_DATA)
      ) u_stage (
         .clk    (clk),
         .rst    (rst),
         .v_in   (v_chain[r-1]),
         .st_in  (st_chain[r-1]),
         .rk     (rk_nxt[r]),
         .v_out  (v_chain[r]),
         .st_out (st_chain[r])
      );

      if (r < NR) begin : g_keyreg
         if (CLEAR_DATA) begin : g_krst
            always_ff @(posedge clk) begin
               if (rst)               rk_q[r] <= '0;
               else if (v_chain[r-1]) rk_q[r] <= rk_nxt[r];
            end
         end else begin : g_kfree
            always_ff @(posedge clk) begin
               if (v_chain[r-1]) rk_q[r] <= rk_nxt[r];
            end
         end
      end
   end

   assign out_valid  = v_chain[NR];
   assign ciphertext = st_chain[NR];

   // fill counter for the latency check
   logic [CNT_W-1:0] fill_cnt;
   always_ff @(posedge clk) begin
      if (rst)                          fill_cnt <= '0;
      else if (fill_cnt != CNT_W'(LAT)) fill_cnt <= fill_cnt + 1'b1;
   end

   AST_ENTRY_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> v0_q); // R3
   AST_FILL_LATENCY: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (fill_cnt == CNT_W'(LAT))); // R2

endmodule

// File: tb/test_aes128_pipe_enc.sv
`timescale 1ns/1ps
module test_aes128_pipe_enc;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [127:0] plaintext = '0;
   logic [127:0] key = '0;
   logic         out_valid;
   logic [127:0] ciphertext;

   aes128_pipe_enc i_aes128_pipe_enc (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .plaintext  (plaintext),
      .key        (key),
      .out_valid  (out_valid),
      .ciphertext (ciphertext)
   );

   always #4 clk = ~clk;

   int edges = 0;
   always @(posedge clk) edges <= edges + 1;

   int           n_checks = 0;
   int           n_fail   = 0;
   int           n_out    = 0;
   string        cur_req  = "R6";
   logic [127:0] last_ct  = '0;
   logic [31:0]  seed     = 32'h1234_5678;
   logic [7:0]   sbox_t [256];

   typedef struct {
      int           due;
      logic [127:0] ct;
   } exp_t;
   exp_t q[$];

   function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p;
      logic [7:0] x;
      logic [7:0] y;
      p = 0;
      x = a;
      y = b;
      for (int i = 0; i < 8; i++) begin
         if (y[0]) p = p ^ x;
         x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
         y = y >> 1;
      end
      return gmul_ret(p);
   endfunction

   function automatic logic [7:0] gmul_ret(input logic [7:0] v);
      return v;
   endfunction

   function automatic logic [127:0] ref_encrypt(input logic [127:0] pt, input logic [127:0] k);
      logic [7:0]   s [16];
      logic [7:0]   w [16];
      logic [7:0]   t [16];
      logic [7:0]   tmp [4];
      logic [7:0]   rc;
      logic [7:0]   a0, a1, a2, a3;
      logic [127:0] res;
      rc = 8'h01;
      for (int i = 0; i < 16; i++) begin
         w[i] = k[127-8*i -: 8];
         s[i] = pt[127-8*i -: 8] ^ w[i];
      end
      for (int rnd = 1; rnd <= 10; rnd++) begin
         tmp[0] = sbox_t[w[13]] ^ rc;
         tmp[1] = sbox_t[w[14]];
         tmp[2] = sbox_t[w[15]];
         tmp[3] = sbox_t[w[12]];
         for (int i = 0; i < 4; i++) w[i] = w[i] ^ tmp[i];
         for (int i = 4; i < 16; i++) w[i] = w[i] ^ w[i-4];
         rc = gmul(rc, 8'h02);
         for (int i = 0; i < 16; i++) t[i] = sbox_t[s[i]];
         for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
               s[4*c+r] = t[4*((c+r)%4)+r];
         if (rnd < 10) begin
            for (int c = 0; c < 4; c++) begin
               a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
               s[4*c]   = gmul(a0, 8'h02) ^ gmul(a1, 8'h03) ^ a2 ^ a3;
               s[4*c+1] = a0 ^ gmul(a1, 8'h02) ^ gmul(a2, 8'h03) ^ a3;
               s[4*c+2] = a0 ^ a1 ^ gmul(a2, 8'h02) ^ gmul(a3, 8'h03);
               s[4*c+3] = gmul(a0, 8'h03) ^ a1 ^ a2 ^ gmul(a3, 8'h02);
            end
         end
         for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[i];
      end
      res = '0;
      for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
      return res;
   endfunction

   function automatic logic [31:0] next_rand(input logic [31:0] v);
      logic [31:0] x;
      x = v;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   task automatic rand_blk(output logic [127:0] b);
      for (int i = 0; i < 4; i++) begin
         seed = next_rand(seed);
         b[127-32*i -: 32] = seed;
      end
   endtask

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one clock: compare outputs at the falling edge, then drive the next inputs
   task automatic step(input bit r, input bit v, input logic [127:0] p, input logic [127:0] k);
      bit ev;
      @(negedge clk);
      ev = (q.size() > 0) && (q[0].due == edges);
      chk(out_valid === ev, cur_req, {127'b0, out_valid}, {127'b0, ev});
      if (out_valid === 1'b1) begin
         n_out++;
         last_ct = ciphertext;
      end
      if (ev) begin
         if (out_valid === 1'b1) chk(ciphertext === q[0].ct, cur_req, ciphertext, q[0].ct);
         void'(q.pop_front());
      end
      rst       = r;
      in_valid  = v;
      plaintext = p;
      key       = k;
      if (r) q.delete();
      else if (v) q.push_back('{due: edges + 11, ct: ref_encrypt(p, k)});
   endtask

   task automatic drain(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0);
   endtask

   initial begin
      #(8 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL R3 watchdog: actual run still going, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [127:0] p, k, fixed_k;
      int           t0, seen, base, sent;

      // reference S-box by brute-force inversion and the affine step
      for (int x = 0; x < 256; x++) begin
         logic [7:0] inv;
         logic [7:0] sv;
         inv = 8'h00;
         if (x != 0)
            for (int y = 1; y < 256; y++)
               if (gmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
         for (int b = 0; b < 8; b++)
            sv[b] = inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^ inv[(b+7)%8]
                    ^ ((8'h63 >> b) & 8'h01) != 0;
         sbox_t[x] = sv;
      end

      // R6: reset state
      cur_req = "R6";
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, '0, '0);
      chk(out_valid === 1'b0, "R6", {127'b0, out_valid}, 128'd0);
      step(1'b0, 1'b0, '0, '0);

      // R1 and R2: known-answer block, exact latency
      cur_req = "R2";
      step(1'b0, 1'b1, 128'h00112233445566778899aabbccddeeff,
           128'h000102030405060708090a0b0c0d0e0f);
      t0   = edges;
      seen = -1;
      for (int i = 0; i < 14; i++) begin
         step(1'b0, 1'b0, '0, '0);
         if (out_valid === 1'b1 && seen < 0) seen = edges;
      end
      chk(seen - t0 == 11, "R2", 128'(seen - t0), 128'd11);
      chk(last_ct === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1", last_ct,
          128'h69c4e0d86a7b0430d8cdb78070b4c55a);

      // R7: final round without MixColumns
      cur_req = "R7";
      step(1'b0, 1'b1, 128'h3243f6a8885a308d313198a2e0370734,
           128'h2b7e151628aed2a6abf7158809cf4f3c);
      drain(13);
      chk(last_ct === 128'h3925841d02dc09fbdc118597196a0b32, "R7", last_ct,
          128'h3925841d02dc09fbdc118597196a0b32);

      // R8: all-zero block, every first-round byte substitutes 00
      cur_req = "R8";
      step(1'b0, 1'b1, '0, '0);
      drain(13);
      chk(last_ct === 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R8", last_ct,
          128'h66e94bd4ef8a2c3b884cfa59ca342b2e);

      // R3: back-to-back stream under one key
      cur_req = "R3";
      rand_blk(fixed_k);
      base = n_out;
      for (int i = 0; i < 40; i++) begin
         rand_blk(p);
         step(1'b0, 1'b1, p, fixed_k);
      end
      drain(14);
      chk(n_out - base == 40, "R3", 128'(n_out - base), 128'd40);

      // R4: new key on every clock
      cur_req = "R4";
      base = n_out;
      for (int i = 0; i < 40; i++) begin
         rand_blk(p);
         rand_blk(k);
         step(1'b0, 1'b1, p, k);
      end
      drain(14);
      chk(n_out - base == 40, "R4", 128'(n_out - base), 128'd40);

      // R5: gaps with noise on idle inputs
      cur_req = "R5";
      base = n_out;
      sent = 0;
      for (int i = 0; i < 80; i++) begin
         bit v;
         rand_blk(p);
         rand_blk(k);
         seed = next_rand(seed);
         v = seed[3] ^ seed[11];
         if (v) sent++;
         step(1'b0, v, p, k);
      end
      drain(14);
      chk(n_out - base == sent, "R5", 128'(n_out - base), 128'(sent));

      // R6: reset while blocks are in flight
      cur_req = "R6";
      base = n_out;
      for (int i = 0; i < 8; i++) begin
         rand_blk(p);
         rand_blk(k);
         step(1'b0, 1'b1, p, k);
      end
      rand_blk(p);
      step(1'b1, 1'b1, p, p);
      drain(15);
      chk(n_out - base == 0, "R6", 128'(n_out - base), 128'd0);
      step(1'b0, 1'b1, 128'h00112233445566778899aabbccddeeff,
           128'h000102030405060708090a0b0c0d0e0f);
      drain(13);
      chk(last_ct === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R6", last_ct,
          128'h69c4e0d86a7b0430d8cdb78070b4c55a);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule